// File: doc/BRIEF.md
# Machine-Cycle Reset Qualifier and Sequencer

This block turns a raw, asynchronous, active-high reset pin into the controller's internal reset. The pin is first brought into the oscillator clock domain. It is then looked at only once per 12-period machine cycle, at one fixed state/phase slot, which an external machine-state counter indicates. A single high look arms the block. From that moment the ports keep doing what they were doing for a fixed number of oscillator periods. If the following look also finds the pin high, the internal reset asserts when that hold window ends.

While the internal reset is active, the block raises a load enable for every special function register except the serial data buffer. It also presents each register's reset byte. The reset is released on the first sample slot that finds the pin low. In that same cycle a restart strobe tells the machine-state counter to begin again at state 1 phase 1. On-chip RAM has no connection to this block and is never written.

Top module: `mcrst_top`

## Requirements
- R1: The synchronized pin is sampled only in the cycle where `mc_state` is 5 and `mc_phase` is 1 (phase 2). The pin passes through a two-flop synchronizer, so a level reaches a sample only if it was driven at least two clock edges before that sample edge. A high sample taken while idle sets `port_hold` in the next cycle.
- R2: `int_rst` asserts only after two consecutive samples are both high. An armed block whose next sample sees the pin low returns to idle without ever asserting `int_rst`.
- R3: `int_rst` rises exactly 19 clock cycles after the clock edge that took the first high sample. `port_hold` stays high from that sample until `int_rst` rises, and the two outputs are never high together.
- R4: `int_rst` stays high while samples keep finding the pin high. It falls on the first sample edge that sees the pin low, and `int_rst` never changes at any other edge.
- R5: `seq_restart` is high during the cycle whose sample releases the reset, so the state counter's next value is state 1 phase 1.
- R6: `sfr_load` has one bit per register. It is all zeros while `int_rst` is low. While `int_rst` is high, every bit is 1 except bit 21 (serial buffer). The register index order is: 0 accumulator, 1 B, 2 status word, 3 stack pointer, 4/5 data pointer low/high, 6/7 program counter low/high, 8..11 ports 0..3, 12 interrupt priority, 13 interrupt enable, 14 timer mode, 15 timer control, 16/17 timer 0 low/high, 18/19 timer 1 low/high, 20 serial control, 21 serial buffer, 22 power control.
- R7: `sfr_value` byte i (bits 8i+7..8i) is the reset byte of register i. Ports 0..3 are FF, the stack pointer is 07, and every other register is 00, including both program counter bytes. Bits left undefined in the priority, enable and power-control registers are driven 0.
- R8: While the synchronous `rst` is high, and in the cycle after it, `int_rst`, `port_hold`, `seq_restart` and `sfr_load` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset of the block's own flops |
| rst_pin | input | 1 | Raw asynchronous reset pin, active high |
| mc_state | input | 3 | Current machine state, 1..6 |
| mc_phase | input | 1 | Current phase within the state, 0 = P1, 1 = P2 |
| int_rst | output | 1 | Internal reset to the controller |
| port_hold | output | 1 | Ports keep their current activity (reset pending) |
| seq_restart | output | 1 | Forces the state counter to state 1 phase 1 at the next edge |
| sfr_load | output | 23 | Per-register reset-load enable |
| sfr_value | output | 184 | Per-register reset byte, byte i for register i |

## Verification
The hardest case to reach is a pin edge that lands close to the single sample slot. There, a change of one or two cycles decides whether the synchronizer delivers the level in time, which in turn decides whether the reset qualifies. The stimulus aligns itself to the start of a machine cycle using a counter model that follows `seq_restart`. It then places pulse starts and lengths at chosen offsets: just inside and just outside the synchronizer window, exactly one machine cycle long, and long enough for two samples. The release edge is reached by holding the pin across several samples before dropping it, so that both the hold behaviour and the restart cycle can be observed.

// File: rtl/mcrst_pkg.sv
package mcrst_pkg;

    // Register slots in the reset-load vector; the order defines bit/byte positions
    typedef enum logic [4:0] {
        SFR_ACC, SFR_B, SFR_PSW, SFR_SP, SFR_DPL, SFR_DPH, SFR_PCL, SFR_PCH,
        SFR_P0, SFR_P1, SFR_P2, SFR_P3, SFR_IP, SFR_IE, SFR_TMOD, SFR_TCON,
        SFR_TL0, SFR_TH0, SFR_TL1, SFR_TH1, SFR_SCON, SFR_SBUF, SFR_PCON,
        SFR_COUNT
    } sfr_idx_e;

    localparam int NUM_SFR = int'(SFR_COUNT);
    localparam int SFR_W   = 8;

    // Qualifier phases
    typedef enum logic [1:0] {
        Q_IDLE   = 2'd0,
        Q_ARMED  = 2'd1,
        Q_ACTIVE = 2'd2
    } qual_e;

    // Machine timing slot seen by the sampler
    typedef struct packed {
        logic [2:0] state;
        logic       phase;
    } mslot_t;

    // Reset byte of a register; undefined bits are driven low
    function automatic logic [SFR_W-1:0] sfr_reset_byte(input int idx);
        logic [SFR_W-1:0] v;
        case (idx)
            int'(SFR_P0), int'(SFR_P1), int'(SFR_P2), int'(SFR_P3): v = 8'hFF;
            int'(SFR_SP):                                           v = 8'h07;
            default:                                                v = 8'h00;
        endcase
        return v;
    endfunction

    // The serial data buffer keeps its content through reset
    function automatic logic sfr_reloads(input int idx);
        return idx != int'(SFR_SBUF);
    endfunction

endpackage

// File: rtl/mcrst_sync.sv
module mcrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mcrst_qual.sv
module mcrst_qual
    import mcrst_pkg::*;
#(
    parameter int HOLD_PERIODS    = 19,
    parameter int CONFIRM_SAMPLES = 2,
    parameter int SAMPLE_STATE    = 5,
    parameter int SAMPLE_PHASE    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_s,
    input  logic [2:0] mc_state,
    input  logic       mc_phase,
    output logic       int_rst,
    output logic       port_hold,
    output logic       seq_restart
);
    localparam int CW = $clog2(HOLD_PERIODS + 1);
    localparam int HW = $clog2(CONFIRM_SAMPLES + 1);

    qual_e   q;
    logic [CW-1:0] cnt;
    logic [HW-1:0] hits;
    mslot_t  slot;
    logic    strobe;
    logic    confirmed;
    logic    window_done;

    assign slot        = '{state: mc_state, phase: mc_phase};
    assign strobe      = (slot.state == 3'(SAMPLE_STATE)) && (slot.phase == 1'(SAMPLE_PHASE));
    assign confirmed   = hits >= HW'(CONFIRM_SAMPLES);
    assign window_done = cnt >= CW'(HOLD_PERIODS);

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= Q_IDLE;
            cnt  <= '0;
            hits <= '0;
        end else begin
            case (q)
                Q_IDLE: begin
                    if (strobe && pin_s) begin
                        q    <= Q_ARMED;
                        cnt  <= CW'(1);
                        hits <= HW'(1);
                    end
                end
                Q_ARMED: begin
                    if (strobe && !pin_s) begin
                        q    <= Q_IDLE;
                        cnt  <= '0;
                        hits <= '0;
                    end else if (window_done && confirmed) begin
                        q    <= Q_ACTIVE;
                        cnt  <= '0;
                        hits <= '0;
                    end else begin
                        if (!window_done) cnt <= cnt + CW'(1);
                        if (strobe && !confirmed) hits <= hits + HW'(1);
                    end
                end
                Q_ACTIVE: begin
                    if (strobe && !pin_s) q <= Q_IDLE;
                end
                default: q <= Q_IDLE;
            endcase
        end
    end

    assign int_rst     = (q == Q_ACTIVE);
    assign port_hold   = (q == Q_ARMED);
    assign seq_restart = (q == Q_ACTIVE) && strobe && !pin_s;
endmodule

// File: rtl/mcrst_load.sv
module mcrst_load
    import mcrst_pkg::*;
(
    input  logic                     int_rst,
    output logic [NUM_SFR-1:0]       sfr_load,
    output logic [NUM_SFR*SFR_W-1:0] sfr_value
);
    for (genvar i = 0; i < NUM_SFR; i++) begin : g_reg
        assign sfr_load[i]               = int_rst & sfr_reloads(i);
        assign sfr_value[i*SFR_W +: SFR_W] = sfr_reset_byte(i);
    end
endmodule

// File: rtl/mcrst_top.sv
module mcrst_top
    import mcrst_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int HOLD_PERIODS    = 19,
    parameter int CONFIRM_SAMPLES = 2,
    parameter int SAMPLE_STATE    = 5,
    parameter int SAMPLE_PHASE    = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rst_pin,
    input  logic [2:0]               mc_state,
    input  logic                     mc_phase,
    output logic                     int_rst,
    output logic                     port_hold,
    output logic                     seq_restart,
    output logic [NUM_SFR-1:0]       sfr_load,
    output logic [NUM_SFR*SFR_W-1:0] sfr_value
);
    logic pin_s;

    mcrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rst_pin),
        .dout (pin_s)
    );

    mcrst_qual #(
        .HOLD_PERIODS    (HOLD_PERIODS),
        .CONFIRM_SAMPLES (CONFIRM_SAMPLES),
        .SAMPLE_STATE    (SAMPLE_STATE),
        .SAMPLE_PHASE    (SAMPLE_PHASE)
    ) u_qual (
        .clk         (clk),
        .rst         (rst),
        .pin_s       (pin_s),
        .mc_state    (mc_state),
        .mc_phase    (mc_phase),
        .int_rst     (int_rst),
        .port_hold   (port_hold),
        .seq_restart (seq_restart)
    );

    mcrst_load u_load (
        .int_rst   (int_rst),
        .sfr_load  (sfr_load),
        .sfr_value (sfr_value)
    );
endmodule

// File: rtl/mcrst_chk.sv
module mcrst_chk
    import mcrst_pkg::*;
#(
    parameter int SAMPLE_STATE = 5,
    parameter int SAMPLE_PHASE = 1
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         mc_state,
    input logic               mc_phase,
    input logic               int_rst,
    input logic               port_hold,
    input logic               seq_restart,
    input logic [NUM_SFR-1:0] sfr_load
);
    logic at_slot;
    assign at_slot = (mc_state == 3'(SAMPLE_STATE)) && (mc_phase == 1'(SAMPLE_PHASE));

    a_r1_arm_at_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(port_hold) |-> $past(at_slot));

    a_r3_hold_before_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(int_rst) |-> $past(port_hold));

    a_r3_never_both: assert property (@(posedge clk) disable iff (rst)
        !(int_rst && port_hold));

    a_r4_release_at_slot: assert property (@(posedge clk) disable iff (rst)
        $fell(int_rst) |-> $past(at_slot));

    a_r5_restart_on_release: assert property (@(posedge clk) disable iff (rst)
        $fell(int_rst) |-> $past(seq_restart));

    a_r6_no_load_idle: assert property (@(posedge clk) disable iff (rst)
        !int_rst |-> (sfr_load == '0));

    a_r7_buffer_kept: assert property (@(posedge clk) disable iff (rst)
        !sfr_load[SFR_SBUF]);
endmodule

bind mcrst_top mcrst_chk #(
    .SAMPLE_STATE (SAMPLE_STATE),
    .SAMPLE_PHASE (SAMPLE_PHASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mc_state    (mc_state),
    .mc_phase    (mc_phase),
    .int_rst     (int_rst),
    .port_hold   (port_hold),
    .seq_restart (seq_restart),
    .sfr_load    (sfr_load)
);

// File: tb/sim_mcrst_top.sv
`timescale 1ns/1ps
module sim_mcrst_top;
    import mcrst_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin = 1'b0;
    logic [2:0] mc_state;
    logic mc_phase;
    logic int_rst, port_hold, seq_restart;
    logic [NUM_SFR-1:0] sfr_load;
    logic [NUM_SFR*SFR_W-1:0] sfr_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcrst_top u0 (
        .clk(clk), .rst(rst), .rst_pin(rst_pin),
        .mc_state(mc_state), .mc_phase(mc_phase),
        .int_rst(int_rst), .port_hold(port_hold), .seq_restart(seq_restart),
        .sfr_load(sfr_load), .sfr_value(sfr_value)
    );

    // Machine-state counter model: S1P1..S6P2, restarts on request
    always @(posedge clk) begin
        if (rst || seq_restart) begin
            mc_state <= 3'd1;
            mc_phase <= 1'b0;
        end else if (mc_phase == 1'b0) begin
            mc_phase <= 1'b1;
        end else begin
            mc_phase <= 1'b0;
            mc_state <= (mc_state == 3'd6) ? 3'd1 : mc_state + 3'd1;
        end
    end

    // Activity monitor for the vector loop
    logic mon_clr = 1'b0;
    logic seen_rst, seen_hold;
    always @(negedge clk) begin
        if (mon_clr) begin
            seen_rst  = 1'b0;
            seen_hold = 1'b0;
        end else begin
            if (int_rst)   seen_rst  = 1'b1;
            if (port_hold) seen_hold = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align();
        @(negedge clk);
        while (!(mc_state == 3'd1 && mc_phase == 1'b0)) @(negedge clk);
    endtask

    // {start offset[3:0], length[7:0], expect reset, expect hold}
    localparam logic [13:0] VEC [6] = '{
        {4'd0, 8'd12, 1'b0, 1'b1},   // one sample high, next low: R2
        {4'd0, 8'd24, 1'b1, 1'b1},   // two samples high: R2
        {4'd8, 8'd24, 1'b1, 1'b1},   // misses first slot via synchronizer: R1
        {4'd8, 8'd14, 1'b0, 1'b1},   // late start, one sample only: R1 R2
        {4'd0, 8'd6,  1'b0, 1'b0},   // gone before any sample: R1
        {4'd0, 8'd40, 1'b1, 1'b1}    // long hold: R4
    };

    logic [NUM_SFR-1:0] exp_mask;

    initial begin
        exp_mask = '1;
        exp_mask[SFR_SBUF] = 1'b0;

        // R8: reset state
        tick(3);
        chk(int_rst == 1'b0,     "R8 int_rst in reset", 32'(int_rst), 0);
        chk(port_hold == 1'b0,   "R8 port_hold in reset", 32'(port_hold), 0);
        chk(sfr_load == '0,      "R8 sfr_load in reset", 32'(sfr_load), 0);
        rst = 1'b0;
        tick(1);
        chk(int_rst == 1'b0 && port_hold == 1'b0 && seq_restart == 1'b0,
            "R8 outputs after reset", {29'd0, int_rst, port_hold, seq_restart}, 0);

        // Vector loop
        foreach (VEC[k]) begin
            align();
            mon_clr = 1'b1;
            tick(1);
            mon_clr = 1'b0;
            align();
            tick(int'(VEC[k][13:10]));
            rst_pin = 1'b1;
            tick(int'(VEC[k][9:2]));
            rst_pin = 1'b0;
            tick(40);
            chk(seen_rst == VEC[k][1], $sformatf("R2 vector %0d reset", k), 32'(seen_rst), 32'(VEC[k][1]));
            chk(seen_hold == VEC[k][0], $sformatf("R1 vector %0d hold", k), 32'(seen_hold), 32'(VEC[k][0]));
            chk(int_rst == 1'b0 && port_hold == 1'b0, $sformatf("R4 vector %0d idle after", k),
                {30'd0, int_rst, port_hold}, 0);
        end

        // Directed timing: pin raised in cycle 0 of an aligned machine cycle
        align();
        rst_pin = 1'b1;
        tick(9);   // cycle 9 = sample slot
        chk(port_hold == 1'b0, "R1 hold before sample edge", 32'(port_hold), 0);
        tick(1);   // cycle 10
        chk(port_hold == 1'b1, "R1 hold after first sample", 32'(port_hold), 1);
        tick(18);  // cycle 28
        chk(int_rst == 1'b0 && port_hold == 1'b1, "R3 one cycle before assert",
            {30'd0, int_rst, port_hold}, 32'b01);
        tick(1);   // cycle 29
        chk(int_rst == 1'b1 && port_hold == 1'b0, "R3 assert after 19 cycles",
            {30'd0, int_rst, port_hold}, 32'b10);
        chk(sfr_load == exp_mask, "R6 load mask", 32'(sfr_load), 32'(exp_mask));
        chk(sfr_value[SFR_SP*8 +: 8] == 8'h07, "R7 stack pointer", 32'(sfr_value[SFR_SP*8 +: 8]), 32'h07);
        chk(sfr_value[SFR_P0*8 +: 8] == 8'hFF && sfr_value[SFR_P3*8 +: 8] == 8'hFF, "R7 port latches",
            {16'd0, sfr_value[SFR_P0*8 +: 8], sfr_value[SFR_P3*8 +: 8]}, 32'hFFFF);
        chk(sfr_value[SFR_PCL*8 +: 16] == 16'h0000, "R7 program counter", 32'(sfr_value[SFR_PCL*8 +: 16]), 0);
        chk(sfr_value[SFR_IP*8 +: 16] == 16'h0000 && sfr_value[SFR_PCON*8 +: 8] == 8'h00,
            "R7 undefined bits low", {8'd0, sfr_value[SFR_IP*8 +: 16], sfr_value[SFR_PCON*8 +: 8]}, 0);
        chk(sfr_value[SFR_ACC*8 +: 8] == 8'h00, "R7 accumulator", 32'(sfr_value[SFR_ACC*8 +: 8]), 0);
        tick(21);  // cycle 50, two high samples passed
        chk(int_rst == 1'b1, "R4 stays while pin high", 32'(int_rst), 1);
        rst_pin = 1'b0;
        tick(7);   // cycle 57 = sample slot that sees the pin low
        chk(int_rst == 1'b1 && seq_restart == 1'b1, "R5 restart in release cycle",
            {30'd0, int_rst, seq_restart}, 32'b11);
        tick(1);   // cycle 58
        chk(int_rst == 1'b0, "R4 released", 32'(int_rst), 0);
        chk(mc_state == 3'd1 && mc_phase == 1'b0, "R5 counter at S1P1",
            {28'd0, mc_state, mc_phase}, 32'b0010);
        chk(sfr_load == '0, "R6 no load after release", 32'(sfr_load), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule